// File: doc/BRIEF.md
# Fuse Autoload Controller with Single-Error-Correct, Double-Error-Detect Check

The controller copies the contents of a one-time-programmable fuse array into configuration latches spread across the chip. It runs once after each power-on reset. No software request is needed. It reads the array one word at a time at increasing addresses. Each word is decoded by a single-error-correct, double-error-detect code while that word enters the shift path. The data bits then leave the block one per clock on a serial scan chain. After the final bit of the final word, a one-cycle load strobe tells every consumer on the chain to capture what it holds. The done flag rises on the next cycle.

A correctable error and an uncorrectable error each produce a one-cycle event pulse on its own output, for a system error collector. Each also sets its own sticky status flag, which software reads after the load. A flag clears only on power-on reset or on a write-one-to-clear strobe. Once done is high, the array is not read again, so no further error events can occur until the next power-on reset.

Top module: `fuse_autoload`

## Requirements
- R1: In the first clock cycle after `por_n` goes high, `fuse_rd_en` is high and `fuse_rd_addr` is 0. No other start input exists.
- R2: The read port returns data one cycle after `fuse_rd_en`. Each power-on load issues exactly NUM_WORDS reads, at addresses 0, 1, ..., NUM_WORDS-1 in that order.
- R3: For each word, 32 data bits leave on `chain_data`, most significant bit first, one bit per cycle, during 32 consecutive cycles with `chain_shift` high.
- R4: A stored word is 39 bits. Bits [31:0] hold data, bits [37:32] hold Hamming checks c0..c5 and bit 38 holds overall even parity across all 39 bits. Data bit j sits at the j-th Hamming position (counting from 0) that is not a power of two, starting at position 3. Check ci covers the positions whose bit i is set. When the parity fails, the error is correctable: the data bit whose position equals the syndrome is inverted, and `corr_evt` is high for one cycle, in the cycle the word's first bit is shifted.
- R5: When the syndrome is nonzero and the parity holds, the error is uncorrectable: the raw data bits are shifted unchanged, and `unc_evt` is high in the cycle the word's first bit is shifted.
- R6: `chain_load` is high for exactly one cycle, directly after the last shifted bit of the last word. `load_done` rises in the following cycle and stays high until power-on reset.
- R7: While `load_done` is high, there are no reads, no shifting and no error events.
- R8: `corr_flag` and `unc_flag` are set in the cycle after their event pulse and hold until power-on reset or until a one-cycle high on `clr_corr` or `clr_unc` respectively. Each clear strobe affects only its own flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| fuse_rd_en | output | 1 | Fuse array read request |
| fuse_rd_addr | output | ADDR_W | Fuse word address |
| fuse_rd_data | input | 39 | Stored codeword, valid one cycle after the request |
| chain_data | output | 1 | Serial scan chain data |
| chain_shift | output | 1 | Chain data valid, consumers shift |
| chain_load | output | 1 | One-cycle capture strobe for consumers |
| load_done | output | 1 | Autoload finished |
| clr_corr | input | 1 | Write-one-to-clear for the correctable flag |
| clr_unc | input | 1 | Write-one-to-clear for the uncorrectable flag |
| corr_flag | output | 1 | Sticky: a correctable error was seen |
| unc_flag | output | 1 | Sticky: an uncorrectable error was seen |
| corr_evt | output | 1 | Correctable error pulse to the error collector |
| unc_evt | output | 1 | Uncorrectable error pulse to the error collector |

## Verification
Every result has a fixed latency. A request appears in the first cycle after reset release. The first bit of a word leaves two cycles after that word's request, and its error pulse appears in the same cycle. A sticky flag follows one cycle after its pulse. The load strobe follows the last bit by one cycle, and done follows the strobe by one. A monitor samples every cycle at the falling edge and pops the queued expected bit and error pulse at each shifted bit, so any extra, missing or shifted cycle breaks the ordering. The flag and clear checks are made one cycle after the strobe that drives them.

// File: rtl/fal_pkg.sv
// Package: shared widths, sequencer states and the codeword bit-placement rule.
// Assumes 32 data bits protected by 6 Hamming checks plus one overall parity bit.
package fal_pkg;
    localparam int DATA_W = 32;
    localparam int HAM_W  = 6;
    localparam int CW_W   = DATA_W + HAM_W + 1;
    localparam int CNT_W  = $clog2(DATA_W);

    typedef enum logic [2:0] {
        ST_REQ,
        ST_CAP,
        ST_SHIFT,
        ST_LOAD,
        ST_DONE
    } fal_state_e;

    // Hamming position of data bit j: j-th non-power-of-two position from 3 upward.
    function automatic int data_pos(input int j);
        int k;
        int r;
        k = 0;
        r = 0;
        for (int p = 3; p < 64; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (k == j) r = p;
                k++;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/fal_ecc_dec.sv
// Module: combinational SECDED decoder for one fuse codeword.
// Assumes layout {parity, c5..c0, data[31:0]} with even overall parity.
// Corrects a single data-bit error; reports double errors without changing data.
module fal_ecc_dec
    import fal_pkg::*;
(
    input  logic [CW_W-1:0]   cw,
    output logic [DATA_W-1:0] data_out,
    output logic              corr_det,
    output logic              unc_det
);
    logic [HAM_W-1:0] syn;
    logic             par_err;

    // Syndrome, parity check and single-bit correction.
    always_comb begin
        syn = cw[DATA_W +: HAM_W];
        for (int j = 0; j < DATA_W; j++) begin
            for (int i = 0; i < HAM_W; i++) begin
                if (((data_pos(j) >> i) & 1) == 1) syn[i] = syn[i] ^ cw[j];
            end
        end
        par_err  = ^cw;
        data_out = cw[DATA_W-1:0];
        if (par_err) begin
            for (int j = 0; j < DATA_W; j++) begin
                if (syn == HAM_W'(data_pos(j))) data_out[j] = ~cw[j];
            end
        end
        corr_det = par_err;
        unc_det  = !par_err && (syn != '0);
    end
endmodule

// File: rtl/fal_seq.sv
// Module: autoload sequencer. Starts on power-on reset release, reads each
// fuse word once in address order, times the 32 shift cycles, then issues the
// load strobe and parks in the done state until the next power-on reset.
module fal_seq
    import fal_pkg::*;
#(
    parameter int NUM_WORDS = 4,
    parameter int ADDR_W    = 2
) (
    input  logic              clk,
    input  logic              por_n,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              cap,
    output logic              shift,
    output logic              load,
    output logic              done
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_WORDS - 1);
    localparam logic [CNT_W-1:0]  LAST_BIT  = CNT_W'(DATA_W - 1);

    fal_state_e        state;
    logic [ADDR_W-1:0] addr;
    logic [CNT_W-1:0]  cnt;

    // State, word address and bit counter update.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            state <= ST_REQ;
            addr  <= '0;
            cnt   <= '0;
        end else begin
            case (state)
                ST_REQ:   state <= ST_CAP;
                ST_CAP: begin
                    state <= ST_SHIFT;
                    cnt   <= '0;
                end
                ST_SHIFT: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST_BIT) begin
                        if (addr == LAST_ADDR) begin
                            state <= ST_LOAD;
                        end else begin
                            addr  <= addr + 1'b1;
                            state <= ST_REQ;
                        end
                    end
                end
                ST_LOAD:  state <= ST_DONE;
                default:  state <= ST_DONE;
            endcase
        end
    end

    // Decoded control outputs.
    always_comb begin
        rd_en   = (state == ST_REQ);
        rd_addr = addr;
        cap     = (state == ST_CAP);
        shift   = (state == ST_SHIFT);
        load    = (state == ST_LOAD);
        done    = (state == ST_DONE);
    end
endmodule

// File: rtl/fal_status.sv
// Module: error event pulses and sticky flags. An event is registered when a
// word is captured; a flag follows its event and clears only by its strobe or
// power-on reset. Setting wins over a simultaneous clear.
module fal_status (
    input  logic clk,
    input  logic por_n,
    input  logic cap,
    input  logic corr_det,
    input  logic unc_det,
    input  logic clr_corr,
    input  logic clr_unc,
    output logic corr_evt,
    output logic unc_evt,
    output logic corr_flag,
    output logic unc_flag
);
    // Event pulses aligned with the first shifted bit of the word.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            corr_evt <= 1'b0;
            unc_evt  <= 1'b0;
        end else begin
            corr_evt <= cap & corr_det;
            unc_evt  <= cap & unc_det;
        end
    end

    // Sticky flags with write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            corr_flag <= 1'b0;
            unc_flag  <= 1'b0;
        end else begin
            corr_flag <= corr_evt | (corr_flag & ~clr_corr);
            unc_flag  <= unc_evt  | (unc_flag  & ~clr_unc);
        end
    end
endmodule

// File: rtl/fuse_autoload.sv
// Module: fuse autoload controller top. Ties the sequencer, the SECDED
// decoder, the serial shifter and the status block together.
// Assumes a synchronous fuse array with one-cycle read latency.
module fuse_autoload
    import fal_pkg::*;
#(
    parameter int NUM_WORDS = 4,
    localparam int ADDR_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic              clk,
    input  logic              por_n,
    output logic              fuse_rd_en,
    output logic [ADDR_W-1:0] fuse_rd_addr,
    input  logic [CW_W-1:0]   fuse_rd_data,
    output logic              chain_data,
    output logic              chain_shift,
    output logic              chain_load,
    output logic              load_done,
    input  logic              clr_corr,
    input  logic              clr_unc,
    output logic              corr_flag,
    output logic              unc_flag,
    output logic              corr_evt,
    output logic              unc_evt
);
    logic              cap;
    logic              corr_det;
    logic              unc_det;
    logic [DATA_W-1:0] fixed_data;
    logic [DATA_W-1:0] shreg;

    fal_seq #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) seq_i (
        .clk     (clk),
        .por_n   (por_n),
        .rd_en   (fuse_rd_en),
        .rd_addr (fuse_rd_addr),
        .cap     (cap),
        .shift   (chain_shift),
        .load    (chain_load),
        .done    (load_done)
    );

    fal_ecc_dec dec_i (
        .cw       (fuse_rd_data),
        .data_out (fixed_data),
        .corr_det (corr_det),
        .unc_det  (unc_det)
    );

    fal_status stat_i (
        .clk       (clk),
        .por_n     (por_n),
        .cap       (cap),
        .corr_det  (corr_det),
        .unc_det   (unc_det),
        .clr_corr  (clr_corr),
        .clr_unc   (clr_unc),
        .corr_evt  (corr_evt),
        .unc_evt   (unc_evt),
        .corr_flag (corr_flag),
        .unc_flag  (unc_flag)
    );

    // Shift register: load corrected word on capture, move left while shifting.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            shreg <= '0;
        end else if (cap) begin
            shreg <= fixed_data;
        end else if (chain_shift) begin
            shreg <= {shreg[DATA_W-2:0], 1'b0};
        end
    end

    assign chain_data = shreg[DATA_W-1];
endmodule

// File: rtl/fal_checker.sv
// Module: protocol checker for fuse_autoload, attached by bind.
module fal_checker (
    input logic clk,
    input logic por_n,
    input logic fuse_rd_en,
    input logic chain_shift,
    input logic chain_load,
    input logic load_done,
    input logic corr_evt,
    input logic unc_evt,
    input logic corr_flag,
    input logic unc_flag
);
    a_r6_load_single: assert property (@(posedge clk) disable iff (!por_n)
        chain_load |=> !chain_load);
    a_r6_done_follows_load: assert property (@(posedge clk) disable iff (!por_n)
        chain_load |=> load_done);
    a_r6_done_holds: assert property (@(posedge clk) disable iff (!por_n)
        load_done |=> load_done);
    a_r7_quiet_when_done: assert property (@(posedge clk) disable iff (!por_n)
        load_done |-> !(fuse_rd_en || chain_shift || corr_evt || unc_evt));
    a_r3_no_read_while_shift: assert property (@(posedge clk) disable iff (!por_n)
        chain_shift |-> !fuse_rd_en);
    a_r4_events_exclusive: assert property (@(posedge clk) disable iff (!por_n)
        !(corr_evt && unc_evt));
    a_r8_corr_sets: assert property (@(posedge clk) disable iff (!por_n)
        corr_evt |=> corr_flag);
    a_r8_unc_sets: assert property (@(posedge clk) disable iff (!por_n)
        unc_evt |=> unc_flag);
endmodule

bind fuse_autoload fal_checker chk_i (
    .clk         (clk),
    .por_n       (por_n),
    .fuse_rd_en  (fuse_rd_en),
    .chain_shift (chain_shift),
    .chain_load  (chain_load),
    .load_done   (load_done),
    .corr_evt    (corr_evt),
    .unc_evt     (unc_evt),
    .corr_flag   (corr_flag),
    .unc_flag    (unc_flag)
);

// File: tb/fuse_autoload_tb_top.sv
// Bench: scoreboard. The episode task fills the fuse model and queues the
// expected serial bits and error pulses; a monitor pops them at each shifted bit.
module fuse_autoload_tb_top;
    localparam int NW = 4;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        fuse_rd_en;
    logic [1:0]  fuse_rd_addr;
    logic [38:0] fuse_rd_data = '0;
    logic        chain_data, chain_shift, chain_load, load_done;
    logic        clr_corr = 1'b0, clr_unc = 1'b0;
    logic        corr_flag, unc_flag, corr_evt, unc_evt;

    int checks = 0;
    int errors = 0;
    logic [38:0] fmem [NW];
    logic        exp_bits [$];
    logic [1:0]  exp_evt [$];
    int reads = 0;
    int exp_addr = 0;
    int bit_idx = 0;
    int loads = 0;
    logic prev_load = 1'b0;

    always #4 clk = ~clk;

    fuse_autoload #(.NUM_WORDS(NW)) dut_i (
        .clk(clk), .por_n(por_n), .fuse_rd_en(fuse_rd_en), .fuse_rd_addr(fuse_rd_addr),
        .fuse_rd_data(fuse_rd_data), .chain_data(chain_data), .chain_shift(chain_shift),
        .chain_load(chain_load), .load_done(load_done), .clr_corr(clr_corr),
        .clr_unc(clr_unc), .corr_flag(corr_flag), .unc_flag(unc_flag),
        .corr_evt(corr_evt), .unc_evt(unc_evt)
    );

    // Fuse array model with one-cycle read latency.
    always_ff @(posedge clk) if (fuse_rd_en) fuse_rd_data <= fmem[fuse_rd_addr];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [38:0] encode(input logic [31:0] d);
        logic [5:0]  c;
        logic [38:0] w;
        int k;
        c = '0;
        k = 0;
        for (int p = 1; p < 64; p++) begin
            if (k < 32 && (p & (p - 1)) != 0) begin
                for (int i = 0; i < 6; i++) if (((p >> i) & 1) == 1) c[i] = c[i] ^ d[k];
                k++;
            end
        end
        w = {1'b0, c, d};
        w[38] = ^w[37:0];
        return w;
    endfunction

    // Monitor: reads, shifted bits, pulses, strobe and done ordering.
    initial begin
        forever begin
            @(negedge clk);
            if (!por_n) begin
                exp_addr = 0;
                bit_idx = 0;
                prev_load = 1'b0;
            end else begin
                if (fuse_rd_en) begin
                    chk(fuse_rd_addr == 2'(exp_addr), "R2 read order", 32'(fuse_rd_addr), 32'(exp_addr));
                    exp_addr++;
                    reads++;
                end
                if (chain_shift) begin
                    if (exp_bits.size() == 0) begin
                        chk(0, "R3 unexpected shift", 1, 0);
                    end else begin
                        logic eb;
                        eb = exp_bits.pop_front();
                        chk(chain_data == eb, "R3/R4/R5 chain bit", 32'(chain_data), 32'(eb));
                        if (bit_idx == 0) begin
                            logic [1:0] ee;
                            ee = exp_evt.pop_front();
                            chk({unc_evt, corr_evt} == ee, "R4/R5 error pulse", 32'({unc_evt, corr_evt}), 32'(ee));
                        end else begin
                            chk(!corr_evt && !unc_evt, "R4/R5 pulse mid-word", 32'({unc_evt, corr_evt}), 0);
                        end
                        bit_idx = (bit_idx + 1) % 32;
                    end
                end else begin
                    chk(!corr_evt && !unc_evt, "R7 pulse outside shift", 32'({unc_evt, corr_evt}), 0);
                end
                if (chain_load) begin
                    loads++;
                    chk(exp_bits.size() == 0, "R6 load after last bit", 32'(exp_bits.size()), 0);
                end
                if (prev_load) chk(load_done, "R6 done after load", 32'(load_done), 1);
                prev_load = chain_load;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // One power-on load: data words, error masks, expected sticky flags.
    task automatic episode(input logic [31:0] d [NW], input logic [38:0] m [NW], input bit ec, input bit eu);
        exp_bits.delete();
        exp_evt.delete();
        for (int w = 0; w < NW; w++) begin
            logic [38:0] cw;
            logic [31:0] ed;
            int ones;
            cw = encode(d[w]) ^ m[w];
            fmem[w] = cw;
            ones = $countones(m[w]);
            ed = (ones == 2) ? cw[31:0] : d[w];
            for (int b = 31; b >= 0; b--) exp_bits.push_back(ed[b]);
            exp_evt.push_back((ones == 2) ? 2'b10 : (ones == 1) ? 2'b01 : 2'b00);
        end
        por_n = 1'b0;
        repeat (3) tick();
        chk(!load_done && !corr_flag && !unc_flag && !chain_shift && !chain_load,
            "R8 reset state", 32'({load_done, corr_flag, unc_flag}), 0);
        reads = 0;
        loads = 0;
        por_n = 1'b1;
        @(negedge clk);
        chk(fuse_rd_en && fuse_rd_addr == 2'd0, "R1 autostart", 32'({fuse_rd_en, fuse_rd_addr}), 32'h4);
        for (int i = 0; i < 400 && !load_done; i++) @(negedge clk);
        repeat (40) @(negedge clk);
        chk(load_done, "R6 done held", 32'(load_done), 1);
        chk(reads == NW, "R2/R7 read count", 32'(reads), NW);
        chk(loads == 1, "R6 single strobe", 32'(loads), 1);
        chk(corr_flag == ec, "R8 corr flag", 32'(corr_flag), 32'(ec));
        chk(unc_flag == eu, "R8 unc flag", 32'(unc_flag), 32'(eu));
    endtask

    initial begin
        logic [31:0] d [NW];
        logic [38:0] m [NW];
        d = '{32'hA5A5_5A5A, 32'h0000_0000, 32'hFFFF_FFFF, 32'h1234_5678};
        m = '{39'h0, 39'h0, 39'h0, 39'h0};
        episode(d, m, 1'b0, 1'b0);
        d = '{32'h8000_0001, 32'hCAFE_F00D, 32'h0F0F_0F0F, 32'h7654_3210};
        m = '{39'h1 << 5, 39'h0, 39'h1 << 34, 39'h1 << 38};
        episode(d, m, 1'b1, 1'b0);
        #3;
        clr_corr = 1'b1;
        tick();
        clr_corr = 1'b0;
        @(negedge clk);
        chk(!corr_flag, "R8 corr cleared", 32'(corr_flag), 0);
        d = '{32'h0000_FFFF, 32'hDEAD_BEEF, 32'h5555_AAAA, 32'h0000_0001};
        m = '{39'h0, (39'h1 << 0) | (39'h1 << 7), 39'h0, 39'h1 << 31};
        episode(d, m, 1'b1, 1'b1);
        #3;
        clr_unc = 1'b1;
        tick();
        clr_unc = 1'b0;
        @(negedge clk);
        chk(!unc_flag, "R8 unc cleared", 32'(unc_flag), 0);
        chk(corr_flag, "R8 corr kept by unc clear", 32'(corr_flag), 1);
        repeat (30) @(negedge clk);
        chk(reads == NW && load_done, "R7 no reread after done", 32'(reads), NW);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule